// File: doc/BRIEF.md
# Serial Controller Event, Interrupt and DMA Request Unit

This block keeps the event state of a bus-master serial controller and turns it into one level interrupt line and two DMA request lines, one for receive and one for transmit. The transfer engine and the data path sit outside it. They report events through per-bit set strobes, and they drop the two ready flags through per-bit hardware clear strobes. Software reaches four registers through a simple strobe port: the event status, the interrupt enable mask, the DMA enables, and an interrupt vector.

Software acknowledges events in one of two ways. It can write ones to the status register, which clears only the bits it is allowed to clear. It can also read the vector register. That read returns a code for the lowest-numbered pending enabled event and clears that event in the same clock edge. Turning on DMA for a direction removes the matching ready flag from the interrupt mask, so that flag raises a DMA request and not an interrupt.

Top module: `irq_dma_ctrl`

## Requirements
- R1: `irq_o` is high exactly when (status AND mask) is nonzero. It reflects the register state updated at the same clock edge.
- R2: `rx_dreq_o` equals status bit 3 AND DMA-enable bit 15. `tx_dreq_o` equals status bit 4 AND DMA-enable bit 7.
- R3: A DMA-enable write keeps only bits 15 and 7 of the write data. A one in bit 15 clears mask bit 3, and a one in bit 7 clears mask bit 4.
- R4: A mask write keeps write-data bits 5..0 when `NEW_REV` is 1 and bits 4..0 when `NEW_REV` is 0.
- R5: A status write clears the status bits that are one in both the write data and 0x0027 (bits 0, 1, 2, 5). Every other bit, including the ready bits 3 and 4, is left unchanged.
- R6: A one on `hw_clr[i]` clears status bit i.
- R7: A status read returns the stored status, with bit 12 replaced by the value of `bus_busy` in the read cycle.
- R8: A vector read returns (index + 1) of the lowest set bit of (status AND mask), or 0 when that AND is zero, and it clears that status bit.
- R9: When `evt_set[i]` is one, status bit i is one after the edge, whatever clear (hardware, software or vector) hits it in the same cycle.
- R10: A synchronous reset clears status, mask, DMA enables, read data and all three request outputs.
- R11: `reg_rdata` is registered. It takes the selected value at the edge that ends a read cycle and holds otherwise. Select codes: 0 status, 1 mask, 2 vector, 3 DMA enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 mask, 2 vector, 3 DMA enables |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| evt_set | input | DATA_W | Per-bit status set strobes from the transfer engine |
| hw_clr | input | DATA_W | Per-bit status clear strobes from the transfer engine |
| bus_busy | input | 1 | Live bus-busy indication, shown in status reads |
| irq_o | output | 1 | Level interrupt request |
| rx_dreq_o | output | 1 | Receive DMA request |
| tx_dreq_o | output | 1 | Transmit DMA request |

## Verification
The bench targets collisions: a set strobe landing on a bit that a status write or a vector read clears in the same cycle. A design that lets the clear win would lose the event, and a later status or vector read would show it missing. Vector reads are issued with several events pending and with none pending. An encoder that picks the highest bit, returns the raw index, or clears the wrong bit gives a wrong code, or leaves `irq_o` high after the last acknowledge. Status writes of all ones check that the ready flags survive, which a design with a wrong clear mask would break by dropping a DMA request. DMA-enable writes check that the matching mask bit falls, which a design without the suppression would miss by still raising the interrupt.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_DMA    = 2'd3
  } reg_sel_e;

  // Code of the lowest set bit: bit index plus one, 0 when nothing is set.
  // Scans from the top so that the last hit is the lowest bit.
  function automatic logic [5:0] lowest_code(input logic [31:0] v);
    logic [5:0] code;
    code = 6'd0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) code = 6'(i + 1);
    end
    return code;
  endfunction

  // Expand a vector code back to the one-hot bit it names.
  function automatic logic [31:0] code_to_bit(input logic [5:0] code);
    if (code == 6'd0) return 32'd0;
    return 32'd1 << (code - 6'd1);
  endfunction

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] status_d,
  output logic [DATA_W-1:0] status_q
);

  // A set strobe wins over any clear on the same bit.
  always_comb status_d = (status_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i))); // R9

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int DATA_W     = 16,
  parameter bit NEW_REV    = 1'b1,
  parameter int RX_RDY_BIT = 3,
  parameter int TX_RDY_BIT = 4,
  parameter int RX_DMA_BIT = 15,
  parameter int TX_DMA_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we,
  input  logic              dma_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_d,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] dma_d,
  output logic [DATA_W-1:0] dma_q
);

  localparam int MASK_BITS = NEW_REV ? 6 : 5;
  localparam logic [DATA_W-1:0] MASK_KEEP = DATA_W'((1 << MASK_BITS) - 1);
  localparam logic [DATA_W-1:0] DMA_KEEP  =
    DATA_W'((1 << RX_DMA_BIT) | (1 << TX_DMA_BIT));

  always_comb begin
    mask_d = mask_q;
    dma_d  = dma_q;
    if (mask_we) mask_d = wdata & MASK_KEEP;
    if (dma_we) begin
      dma_d = wdata & DMA_KEEP;
      // Enabling DMA for a direction takes its ready flag off the interrupt.
      if (wdata[RX_DMA_BIT]) mask_d[RX_RDY_BIT] = 1'b0;
      if (wdata[TX_DMA_BIT]) mask_d[TX_RDY_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      dma_q  <= '0;
    end else begin
      mask_q <= mask_d;
      dma_q  <= dma_d;
    end
  end

  AST_DMA_SUPPRESS_RX: assert property (@(posedge clk) disable iff (rst)
    (dma_we && !mask_we && wdata[RX_DMA_BIT]) |=> !mask_q[RX_RDY_BIT]); // R3
  AST_DMA_SUPPRESS_TX: assert property (@(posedge clk) disable iff (rst)
    (dma_we && !mask_we && wdata[TX_DMA_BIT]) |=> !mask_q[TX_RDY_BIT]); // R3

endmodule

// File: rtl/irq_vector_enc.sv
module irq_vector_enc #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] pending,
  output logic [5:0]        code,
  output logic [DATA_W-1:0] hit_bit
);
  import irq_dma_pkg::*;

  // Code from the package scan; the one-hot hit from two's-complement isolation.
  always_comb begin
    code    = lowest_code(32'(pending));
    hit_bit = pending & (~pending + DATA_W'(1));
  end

endmodule

// File: rtl/irq_dma_ctrl.sv
module irq_dma_ctrl #(
  parameter int DATA_W      = 16,
  parameter bit NEW_REV     = 1'b1,
  parameter int RX_RDY_BIT  = 3,
  parameter int TX_RDY_BIT  = 4,
  parameter int RX_DMA_BIT  = 15,
  parameter int TX_DMA_BIT  = 7,
  parameter int BUSY_BIT    = 12,
  parameter logic [DATA_W-1:0] SW_CLR_MASK = 'h0027
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] evt_set,
  input  logic [DATA_W-1:0] hw_clr,
  input  logic              bus_busy,
  output logic              irq_o,
  output logic              rx_dreq_o,
  output logic              tx_dreq_o
);
  import irq_dma_pkg::*;

  reg_sel_e          sel;
  logic              wr_status, wr_mask, wr_dma, rd_vector;
  logic [DATA_W-1:0] status_d, status_q, mask_d, mask_q, dma_d, dma_q;
  logic [DATA_W-1:0] sw_clr, vec_clr, all_clr, pending, vec_hit, status_view;
  logic [5:0]        vec_code;

  always_comb begin
    sel       = reg_sel_e'(reg_sel);
    wr_status = reg_wr && (sel == SEL_STATUS);
    wr_mask   = reg_wr && (sel == SEL_MASK);
    wr_dma    = reg_wr && (sel == SEL_DMA);
    rd_vector = reg_rd && (sel == SEL_VECTOR);
    pending   = status_q & mask_q;
    sw_clr    = wr_status ? (reg_wdata & SW_CLR_MASK) : '0;
    vec_clr   = rd_vector ? vec_hit : '0;
    all_clr   = hw_clr | sw_clr | vec_clr;
    status_view           = status_q;
    status_view[BUSY_BIT] = bus_busy;
  end

  irq_vector_enc #(.DATA_W(DATA_W)) u_vec (
    .pending (pending),
    .code    (vec_code),
    .hit_bit (vec_hit)
  );

  irq_status_reg #(.DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .set_i    (evt_set),
    .clr_i    (all_clr),
    .status_d (status_d),
    .status_q (status_q)
  );

  irq_cfg_regs #(
    .DATA_W     (DATA_W),
    .NEW_REV    (NEW_REV),
    .RX_RDY_BIT (RX_RDY_BIT),
    .TX_RDY_BIT (TX_RDY_BIT),
    .RX_DMA_BIT (RX_DMA_BIT),
    .TX_DMA_BIT (TX_DMA_BIT)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .mask_we (wr_mask),
    .dma_we  (wr_dma),
    .wdata   (reg_wdata),
    .mask_d  (mask_d),
    .mask_q  (mask_q),
    .dma_d   (dma_d),
    .dma_q   (dma_q)
  );

  // Request outputs are registered from next state, so they move with the registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      rx_dreq_o <= 1'b0;
      tx_dreq_o <= 1'b0;
    end else begin
      irq_o     <= |(status_d & mask_d);
      rx_dreq_o <= status_d[RX_RDY_BIT] & dma_d[RX_DMA_BIT];
      tx_dreq_o <= status_d[TX_RDY_BIT] & dma_d[TX_DMA_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (sel)
        SEL_STATUS: reg_rdata <= status_view;
        SEL_MASK:   reg_rdata <= mask_q;
        SEL_VECTOR: reg_rdata <= DATA_W'(vec_code);
        default:    reg_rdata <= dma_q;
      endcase
    end
  end

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(status_q & mask_q))); // R1
  AST_RX_DREQ_GATE: assert property (@(posedge clk) disable iff (rst)
    rx_dreq_o |-> (dma_q[RX_DMA_BIT] && status_q[RX_RDY_BIT])); // R2
  AST_TX_DREQ_GATE: assert property (@(posedge clk) disable iff (rst)
    tx_dreq_o |-> (dma_q[TX_DMA_BIT] && status_q[TX_RDY_BIT])); // R2
  AST_READY_SW_IMMUNE: assert property (@(posedge clk) disable iff (rst)
    (wr_status && status_q[RX_RDY_BIT] && !hw_clr[RX_RDY_BIT]) |=> status_q[RX_RDY_BIT]); // R5
  AST_VEC_MATCH: assert property (@(posedge clk) disable iff (rst)
    32'(vec_hit) == code_to_bit(vec_code)); // R8
  AST_VEC_ACK: assert property (@(posedge clk) disable iff (rst)
    (rd_vector && (vec_hit != '0) && ((evt_set & vec_hit) == '0))
      |=> ((status_q & $past(vec_hit)) == '0)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_o && !rx_dreq_o && !tx_dreq_o && reg_rdata == '0)); // R10

endmodule

// File: tb/irq_dma_ctrl_bench.sv
`timescale 1ns/1ps
module irq_dma_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, bus_busy = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0, evt_set = '0, hw_clr = '0;
  logic [15:0] reg_rdata, old_rdata;
  logic        irq_o, rx_dreq_o, tx_dreq_o, old_irq, old_rx, old_tx;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [15:0] m_stat = '0, m_mask = '0, m_dma = '0, m_rdata = '0;

  always #4 clk = ~clk;

  irq_dma_ctrl u_irq_dma_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .hw_clr(hw_clr), .bus_busy(bus_busy), .irq_o(irq_o),
    .rx_dreq_o(rx_dreq_o), .tx_dreq_o(tx_dreq_o)
  );

  irq_dma_ctrl #(.NEW_REV(1'b0)) u_irq_dma_ctrl_old (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(old_rdata), .evt_set(evt_set),
    .hw_clr(hw_clr), .bus_busy(bus_busy), .irq_o(old_irq),
    .rx_dreq_o(old_rx), .tx_dreq_o(old_tx)
  );

  // Bench restatement of the vector code: count upward to the first pending bit.
  function automatic int first_pending(input logic [15:0] p);
    for (int i = 0; i < 16; i++) if (p[i]) return i + 1;
    return 0;
  endfunction

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // One register/strobe cycle; inputs change after a falling edge, outputs
  // are compared at the next falling edge against the bench model.
  task automatic cycle(input logic wr, input logic rd, input logic [1:0] sel,
                       input logic [15:0] wd, input logic [15:0] set,
                       input logic [15:0] hclr, input logic busy, input string tag);
    logic [15:0] clr, view;
    int code;
    reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
    evt_set = set; hw_clr = hclr; bus_busy = busy;
    code = first_pending(m_stat & m_mask);
    if (rd) begin
      view = m_stat; view[12] = busy;
      case (sel)
        2'd0: m_rdata = view;
        2'd1: m_rdata = m_mask;
        2'd2: m_rdata = 16'(code);
        default: m_rdata = m_dma;
      endcase
    end
    clr = hclr;
    if (wr && sel == 2'd0) clr = clr | (wd & 16'h0027);
    if (rd && sel == 2'd2 && code != 0) clr[code-1] = 1'b1;
    m_stat = (m_stat & ~clr) | set;
    if (wr && sel == 2'd1) m_mask = wd & 16'h003f;
    if (wr && sel == 2'd3) begin
      m_dma = wd & 16'h8080;
      if (wd[15]) m_mask[3] = 1'b0;
      if (wd[7])  m_mask[4] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " R1 irq_o"}, 16'(irq_o), 16'(|(m_stat & m_mask)));
    check({tag, " R2 rx_dreq_o"}, 16'(rx_dreq_o), 16'(m_stat[3] & m_dma[15]));
    check({tag, " R2 tx_dreq_o"}, 16'(tx_dreq_o), 16'(m_stat[4] & m_dma[7]));
    check({tag, rd ? " R11 rdata (sel R7/R4/R8/R3)" : " R11 rdata hold"}, reg_rdata, m_rdata);
    reg_wr = 1'b0; reg_rd = 1'b0; evt_set = '0; hw_clr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] w, s, h;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: all outputs quiet after reset
    check("R10 irq_o", 16'(irq_o), 16'd0);
    check("R10 dreqs", 16'({rx_dreq_o, tx_dreq_o}), 16'd0);
    check("R10 rdata", reg_rdata, 16'd0);
    cycle(1'b0, 1'b1, 2'd0, 16'h0, 16'h0, 16'h0, 1'b1, "R10 R7 status after reset, busy shown");
    // R4: mask width by revision
    cycle(1'b1, 1'b0, 2'd1, 16'h00ff, 16'h0, 16'h0, 1'b0, "R4 mask write");
    cycle(1'b0, 1'b1, 2'd1, 16'h0, 16'h0, 16'h0, 1'b0, "R4 mask read");
    check("R4 old revision mask", old_rdata, 16'h001f);
    // R8: lowest first, acknowledge, then empty
    cycle(1'b0, 1'b0, 2'd0, 16'h0, 16'h0025, 16'h0, 1'b0, "R1 raise events");
    cycle(1'b0, 1'b1, 2'd2, 16'h0, 16'h0, 16'h0, 1'b0, "R8 vector first");
    cycle(1'b0, 1'b1, 2'd2, 16'h0, 16'h0, 16'h0, 1'b0, "R8 vector second");
    cycle(1'b0, 1'b1, 2'd2, 16'h0, 16'h0, 16'h0, 1'b0, "R8 vector third");
    cycle(1'b0, 1'b1, 2'd2, 16'h0, 16'h0, 16'h0, 1'b0, "R8 vector empty");
    // R2/R3: ready flags with DMA enables
    cycle(1'b0, 1'b0, 2'd0, 16'h0, 16'h0018, 16'h0, 1'b0, "R1 ready flags");
    cycle(1'b1, 1'b0, 2'd3, 16'hffff, 16'h0, 16'h0, 1'b0, "R3 dma write");
    cycle(1'b0, 1'b1, 2'd3, 16'h0, 16'h0, 16'h0, 1'b0, "R3 dma read");
    cycle(1'b0, 1'b1, 2'd1, 16'h0, 16'h0, 16'h0, 1'b0, "R3 mask suppressed");
    // R5: software cannot clear ready flags
    cycle(1'b1, 1'b0, 2'd0, 16'hffff, 16'h0, 16'h0, 1'b0, "R5 status write ones");
    cycle(1'b0, 1'b1, 2'd0, 16'h0, 16'h0, 16'h0, 1'b0, "R5 status read");
    // R6: hardware clear
    cycle(1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 16'h0008, 1'b0, "R6 hw clear rx ready");
    // R9: set beats software and vector clears
    cycle(1'b1, 1'b0, 2'd1, 16'h003f, 16'h0, 16'h0, 1'b0, "R9 mask all");
    cycle(1'b1, 1'b0, 2'd0, 16'h0002, 16'h0002, 16'h0, 1'b0, "R9 set vs sw clear");
    cycle(1'b0, 1'b1, 2'd0, 16'h0, 16'h0, 16'h0, 1'b0, "R9 status read");
    cycle(1'b0, 1'b1, 2'd2, 16'h0, 16'h0002, 16'h0, 1'b0, "R9 set vs vector clear");
    cycle(1'b0, 1'b1, 2'd0, 16'h0, 16'h0, 16'h0002, 1'b0, "R9 R6 status read");
    // Random mix
    for (int n = 0; n < 3000; n++) begin
      w = 16'($urandom);
      s = 16'($urandom & $urandom & $urandom);
      h = 16'($urandom & $urandom & $urandom);
      cycle(($urandom % 3) == 0, ($urandom % 3) == 0, 2'($urandom), w, s, h,
            1'($urandom), "random");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule